// File: doc/BRIEF.md
# MDIO Management Controller

This block runs clause-22 management frames on an MDC/MDIO pair toward a single external PHY. Software programs it over a small word-addressed register bus: it sets a PHY address and PHY register number, then either writes a 16-bit value into the write-data register, which starts a write frame, or sets a bit in the command register, which starts a read frame. A status bit stays set while a frame is on the wire. When a read frame finishes, the 16 bits the PHY returned can be read from the read-data register.

The MDC clock comes from the system clock through a divisor that software chooses from a fixed, uneven set. After reset the slowest divisor is selected, so that a PHY of unknown speed is still inside its MDC limit. The block drives MDIO through an output value and an output enable. It releases the line during the turnaround and data bits of a read, and it samples the PHY's bits on the rising MDC edge. Only one frame runs at a time.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The address register at offset 0 holds the PHY address in bits 12:8 and the PHY register number in bits 4:0. Both fields read back as written, and all other bits read as zero.
- R2: Writing offset 2 while idle stores bits 15:0 as write data and starts a write frame, sent MSB first: 32 ones, 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits.
- R3: Writing offset 1 with bit 0 set while idle starts a read frame with opcode 10. Bit 0 reads back as written until software clears it. Writing 0 starts no frame.
- R4: In a read frame, MDIO is released (output enable low) for the two turnaround bits and the 16 data bits. The PHY's bits are sampled on rising MDC edges and appear MSB first in bits 15:0 of offset 3.
- R5: Bit 0 of offset 4 (busy) is set from the cycle after a frame is launched until the frame completes. The read-data register changes only in the cycle in which busy clears.
- R6: Offset 5 bits 2:0 choose the MDC divisor: codes 0 to 6 give 4, 6, 8, 10, 14, 20 and 28 system clocks, and code 7 also gives 28. The reset value is code 6. One MDC period equals the chosen divisor, with equal high and low halves.
- R7: MDIO and its output enable change only while MDC is low or on a falling edge. They are stable during every high half of MDC.
- R8: While busy, writes to offset 2 or offset 1 are ignored. They change neither register and launch no further frame.
- R9: While idle, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A PHY model in the bench records every bit on the rising MDC edge and answers reads with random data. A design that sampled on the wrong edge or shifted by one bit would return a rotated result, and a design that drove during the turnaround would show an enable bit set where zeros are expected. The time between MDC rises is measured for every divisor code, including the default and code 7, which catches a wrong entry or an odd half period. Writes made in the middle of a read check that a busy block keeps its write data and command and does not chain a second frame. A design that let them through would show extra MDC edges or changed readback.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_LEN   = 64;
  localparam int DRIVE_RD    = 46;
  localparam int SAMPLE_FROM = 48;
  localparam int DATA_W      = 16;
  localparam int FLD_W       = 5;
  localparam int SEL_W       = 3;
  localparam logic [SEL_W-1:0] SEL_RESET = 3'd6;

  typedef enum logic [2:0] {
    OFS_ADDR   = 3'd0,
    OFS_CMD    = 3'd1,
    OFS_WDATA  = 3'd2,
    OFS_RDATA  = 3'd3,
    OFS_STATUS = 3'd4,
    OFS_CLKCFG = 3'd5
  } reg_ofs_e;

  // half of the MDC period in system clocks, per selection code
  function automatic logic [4:0] half_period(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    half_period = 5'd2;
      3'd1:    half_period = 5'd3;
      3'd2:    half_period = 5'd4;
      3'd3:    half_period = 5'd5;
      3'd4:    half_period = 5'd7;
      3'd5:    half_period = 5'd10;
      default: half_period = 5'd14;
    endcase
  endfunction

  // complete frame, first bit on the wire in bit 63
  function automatic logic [FRAME_LEN-1:0] frame_word(
    input logic             is_rd,
    input logic [FLD_W-1:0] phy,
    input logic [FLD_W-1:0] rnum,
    input logic [DATA_W-1:0] wd);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] body;
    op   = is_rd ? 2'b10 : 2'b01;
    ta   = is_rd ? 2'b11 : 2'b10;
    body = is_rd ? {DATA_W{1'b1}} : wd;
    frame_word = {32'hFFFF_FFFF, 2'b01, op, phy, rnum, ta, body};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             tick_rise,
  output logic             tick_fall
);

  logic [4:0]       cnt;
  logic [SEL_W-1:0] sel_q;
  logic [4:0]       half;
  logic             wrap;

  assign half      = half_period(sel_q);
  assign wrap      = run && (cnt == half - 5'd1);
  assign tick_rise = wrap && !mdc;
  assign tick_fall = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc   <= 1'b0;
      sel_q <= SEL_RESET;
    end else if (!run) begin
      cnt   <= '0;
      mdc   <= 1'b0;
      sel_q <= sel;
    end else if (wrap) begin
      cnt   <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt   <= cnt + 5'd1;
    end
  end

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int LEN    = FRAME_LEN,
  parameter int DRV_RD = DRIVE_RD,
  parameter int SMP_AT = SAMPLE_FROM,
  parameter int RX_W   = DATA_W,
  localparam int IDX_W = $clog2(LEN)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rd,
  input  logic [LEN-1:0]   frame,
  input  logic             tick_rise,
  input  logic             tick_fall,
  input  logic             mdio_i,
  output logic             busy,
  output logic             rd_mode,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             done,
  output logic [RX_W-1:0]  rx_data,
  output logic [IDX_W-1:0] bit_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN - 1);

  logic [LEN-1:0] sh;
  logic           released;

  assign mdio_o   = sh[LEN-1];
  assign released = rd_mode && (bit_idx >= IDX_W'(DRV_RD));
  assign mdio_oe  = busy && !released;
  assign done     = busy && tick_fall && (bit_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      bit_idx <= '0;
      busy    <= 1'b0;
      rd_mode <= 1'b0;
      rx_data <= '0;
    end else if (!busy) begin
      if (start) begin
        sh      <= frame;
        bit_idx <= '0;
        busy    <= 1'b1;
        rd_mode <= start_rd;
      end
    end else begin
      if (tick_rise && rd_mode && bit_idx >= IDX_W'(SMP_AT))
        rx_data <= {rx_data[RX_W-2:0], mdio_i};
      if (tick_fall) begin
        if (bit_idx == LAST_IDX) begin
          busy <= 1'b0;
          sh   <= '1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          sh      <= {sh[LEN-2:0], 1'b1};
        end
      end
    end
  end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rx_data,
  output logic [FLD_W-1:0]  phy_q,
  output logic [FLD_W-1:0]  rnum_q,
  output logic [DATA_W-1:0] wdat_q,
  output logic [DATA_W-1:0] rdat_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              go_wr,
  output logic              go_rd
);

  logic cmd_q;
  logic wr_addr, wr_cmd, wr_wdat, wr_cfg;

  assign wr_addr = bus_wr && (bus_addr == AW'(OFS_ADDR));
  assign wr_cmd  = bus_wr && (bus_addr == AW'(OFS_CMD))   && !busy;
  assign wr_wdat = bus_wr && (bus_addr == AW'(OFS_WDATA)) && !busy;
  assign wr_cfg  = bus_wr && (bus_addr == AW'(OFS_CLKCFG));
  assign go_wr   = wr_wdat;
  assign go_rd   = wr_cmd && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q  <= '0;
      rnum_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      sel_q  <= SEL_RESET;
      cmd_q  <= 1'b0;
    end else begin
      if (wr_addr) begin
        phy_q  <= bus_wdata[12:8];
        rnum_q <= bus_wdata[4:0];
      end
      if (wr_cmd)  cmd_q  <= bus_wdata[0];
      if (wr_wdat) wdat_q <= bus_wdata[DATA_W-1:0];
      if (wr_cfg)  sel_q  <= bus_wdata[SEL_W-1:0];
      if (rd_done) rdat_q <= rx_data;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFS_ADDR):   begin
        bus_rdata[12:8] = phy_q;
        bus_rdata[4:0]  = rnum_q;
      end
      AW'(OFS_CMD):    bus_rdata[0]              = cmd_q;
      AW'(OFS_WDATA):  bus_rdata[DATA_W-1:0]     = wdat_q;
      AW'(OFS_RDATA):  bus_rdata[DATA_W-1:0]     = rdat_q;
      AW'(OFS_STATUS): bus_rdata[0]              = busy;
      AW'(OFS_CLKCFG): bus_rdata[SEL_W-1:0]      = sel_q;
      default:         bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int BUS_AW = 3,
  parameter int BUS_DW = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam int IDX_W = $clog2(FRAME_LEN);

  logic [FLD_W-1:0]     phy_q, rnum_q;
  logic [DATA_W-1:0]    wdat_q, rdat_q, rx_data;
  logic [SEL_W-1:0]     sel_q;
  logic                 go_wr, go_rd, launch;
  logic                 busy, rd_mode, done, rd_done;
  logic                 tick_rise, tick_fall;
  logic [IDX_W-1:0]     bit_idx;
  logic [FRAME_LEN-1:0] frame;

  assign launch  = go_wr || go_rd;
  assign rd_done = done && rd_mode;
  assign frame   = frame_word(go_rd, phy_q, rnum_q, bus_wdata[DATA_W-1:0]);

  mdio_regs #(.AW(BUS_AW), .DW(BUS_DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy(busy), .rd_done(rd_done), .rx_data(rx_data),
    .phy_q(phy_q), .rnum_q(rnum_q), .wdat_q(wdat_q), .rdat_q(rdat_q),
    .sel_q(sel_q), .go_wr(go_wr), .go_rd(go_rd)
  );

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .sel(sel_q),
    .mdc(mdc), .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(launch), .start_rd(go_rd), .frame(frame),
    .tick_rise(tick_rise), .tick_fall(tick_fall), .mdio_i(mdio_i),
    .busy(busy), .rd_mode(rd_mode), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rx_data(rx_data), .bit_idx(bit_idx)
  );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
  parameter int AW    = 3,
  parameter int IDX_W = 6
)(
  input logic              clk,
  input logic              rst_n,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              busy,
  input logic              rd_mode,
  input logic [IDX_W-1:0]  bit_idx,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [15:0]       wdat_q,
  input logic [15:0]       rdat_q
);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_stable_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_mdc_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> $past(busy));

  assert_busy_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_wr));

  assert_rdata_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdat_q) |-> ($fell(busy) && $past(rd_mode)));

  assert_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_mode && bit_idx >= IDX_W'(46)) |-> !mdio_oe);

  assert_wdata_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == AW'(2)) |=> $stable(wdat_q));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.AW(BUS_AW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .rd_mode(rd_mode), .bit_idx(bit_idx),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .wdat_q(wdat_q), .rdat_q(rdat_q)
);

// File: tb/sim_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int edge_cnt = 0;
  int last_rise = 0;
  int per = 0;
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  logic [15:0] phy_resp = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdio_mgmt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic logic resp_bit(input int n, input logic [15:0] v);
    if (n >= 48 && n < 64) return v[63 - n];
    return 1'b1;
  endfunction

  assign mdio_i = resp_bit(edge_cnt, phy_resp);

  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_o};
    oecap = {oecap[62:0], mdio_oe};
    per   = cyc - last_rise;
    last_rise = cyc;
    edge_cnt++;
  end

  function automatic int exp_div(input logic [2:0] code);
    int t[8] = '{4, 6, 8, 10, 14, 20, 28, 28};
    return t[code];
  endfunction

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    logic [63:0] f;
    f = '1;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = p;
    f[22:18] = r;
    f[17:16] = rd ? 2'b11 : 2'b10;
    f[15:0]  = rd ? 16'hFFFF : d;
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(output int waited);
    logic [31:0] s;
    waited = 0;
    do begin
      rd(3'd4, s);
      waited++;
    end while (s[0] && waited < 5000);
  endtask

  task automatic run_txn(input bit is_rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input bit set_sel, input logic [2:0] code);
    logic [31:0] v;
    logic [63:0] ef, eoe;
    int w;
    if (set_sel) wr(3'd5, {29'd0, code});
    wr(3'd0, {19'd0, p, 3'd0, r});
    rd(3'd0, v);
    check(v == {19'd0, p, 3'd0, r}, "R1 address readback", v, {19'd0, p, 3'd0, r});
    phy_resp = d;
    edge_cnt = 0;
    if (is_rd) wr(3'd1, 32'd1); else wr(3'd2, {16'd0, d});
    rd(3'd4, v);
    check(v[0], "R5 busy after launch", v, 1);
    wait_idle(w);
    ef  = exp_frame(is_rd, p, r, d);
    eoe = is_rd ? ~(64'd0) << 18 : ~(64'd0);
    check(edge_cnt == 64, "R2 MDC edge count", edge_cnt, 64);
    check(oecap == eoe, "R4 output enable pattern", oecap, eoe);
    if (is_rd) begin
      check(cap[63:18] == ef[63:18], "R3 read frame header", cap, ef);
      rd(3'd3, v);
      check(v == {16'd0, d}, "R4 read data", v, {16'd0, d});
      wr(3'd1, 32'd0);
    end else begin
      check(cap == ef, "R2 write frame", cap, ef);
    end
    check(per == exp_div(code), "R6 MDC period", per, exp_div(code));
    check(!mdc && !mdio_oe, "R9 idle pins", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    logic [31:0] v;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd4, v); check(v == 0, "R5 reset busy", v, 0);
    rd(3'd5, v); check(v == 6, "R6 reset divisor code", v, 6);
    rd(3'd3, v); check(v == 0, "R4 reset read data", v, 0);
    check(!mdc && !mdio_oe, "R9 reset pins", {mdc, mdio_oe}, 0);

    // default divisor, no configuration write
    run_txn(1'b0, 5'd31, 5'd0, 16'hA5C3, 1'b0, 3'd6);
    // code 7 behaves like the slowest
    run_txn(1'b1, 5'd0, 5'd31, 16'h8001, 1'b1, 3'd7);
    // fastest divisor
    run_txn(1'b1, 5'd1, 5'd2, 16'h7FFE, 1'b1, 3'd0);

    // R3: writing zero to the command register starts nothing
    edge_cnt = 0;
    wr(3'd1, 32'd0);
    rd(3'd4, v); check(v[0] == 0, "R3 zero command idle", v, 0);

    // R8: writes while busy are ignored
    wr(3'd2, 32'h1234);
    wait_idle(w);
    wr(3'd5, 32'd0);
    phy_resp = 16'h5A5A;
    edge_cnt = 0;
    wr(3'd1, 32'd1);
    repeat (20) @(negedge clk);
    wr(3'd2, 32'hBEEF);
    wr(3'd1, 32'd0);
    wr(3'd1, 32'd1);
    wait_idle(w);
    repeat (200) @(negedge clk);
    check(edge_cnt == 64, "R8 no extra frame", edge_cnt, 64);
    rd(3'd2, v); check(v == 32'h1234, "R8 write data kept", v, 32'h1234);
    rd(3'd1, v); check(v == 1, "R8 command kept", v, 1);
    rd(3'd3, v); check(v == 32'h5A5A, "R4 read under busy writes", v, 32'h5A5A);
    wr(3'd1, 32'd0);

    // random mix
    void'($urandom(32'h1F3A));
    for (int i = 0; i < 16; i++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      run_txn(bit'($urandom_range(0, 1)), 5'($urandom), 5'($urandom),
              16'($urandom), 1'b1, c);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 180000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule